// File: doc/BRIEF.md
# Acquisition Interrupt Control Register

This block is a single 32-bit control and status register that drives one host interrupt line for a data-acquisition front end. The main interrupt source can be one of two events, chosen by a mode bit. The first is a one-cycle DMA-complete pulse. The second is the sample FIFO occupancy reaching a programmable threshold, which is picked from a table of seven levels from 32 to 1536 samples.

Two asynchronous external trigger inputs are synchronized and edge-detected. Each has its own sticky status bit and its own interrupt enable. The register also holds two mode enables, one for analog-input post-trigger and one for pre-trigger, and presents them as outputs to the acquisition logic.

Software writes the control fields directly. It clears a pending status bit by writing a 1 to that bit's position. The interrupt line is the OR of every pending status bit whose enable is set.

Top module: `acq_irq_ctrl`

## Requirements
- R1: After reset, every stored field and status bit is 0, the readback is 0x00000C08, and irq is 0.
- R2: A write stores bit 0 (global enable), bit 2 (source mode), bits 7:4 (level code), bit 8 (post-trigger mode), bit 9 (pre-trigger mode), bit 12 (trigger-0 enable) and bit 14 (trigger-1 enable), and these read back. Outputs post_trig_en and pre_trig_en follow bits 8 and 9.
- R3: Bits 3, 10 and 11 always read 1, and bits 31:16 always read 0, whatever value is written.
- R4: The FIFO threshold for level codes 0 to 6 is 32, 64, 128, 256, 512, 1024 and 1536 samples. Codes 7 to 15 give 32.
- R5: When bit 2 is 1, a dma_done pulse sets status bit 1 and FIFO crossings are ignored. When bit 2 is 0, a FIFO crossing sets bit 1 and dma_done is ignored.
- R6: A FIFO event occurs in the cycle where fifo_level >= threshold becomes true, and only then. A level that stays at or above the threshold gives no further event.
- R7: A rising edge on ext_trig[k] sets status bit 13 (k=0) or bit 15 (k=1) on the third rising clock edge after the input rises. An input held high does not set the bit again.
- R8: Status bits 1, 13 and 15 are sticky. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a set and a clear arrive in the same cycle, the set wins.
- R9: irq = (bit0 & bit1) | (bit12 & bit13) | (bit14 & bit15), evaluated from the current register contents.
- R10: Status bits are set whether or not their enables are set. The enables gate only irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register readback |
| fifo_level | input | CNT_W | Sample FIFO occupancy |
| dma_done | input | 1 | DMA-complete pulse |
| ext_trig | input | 2 | Asynchronous external trigger inputs |
| post_trig_en | output | 1 | Analog-input post-trigger mode enable |
| pre_trig_en | output | 1 | Analog-input pre-trigger mode enable |
| irq | output | 1 | Host interrupt |

## Verification
The bench builds the block with CNT_W = 11, the narrowest occupancy count that can hold 1536. At this width the bench can place the count exactly one sample below every threshold and then exactly at it. It does this for all sixteen level codes, including the codes that fold back to 32. The default synchronizer depth of two keeps the trigger set latency at three clock edges, and the bench checks that exact cycle.

// File: rtl/acq_irq_pkg.sv
package acq_irq_pkg;
  localparam int NUM_TRIG   = 2;
  localparam int BIT_IEN    = 0;
  localparam int BIT_MST    = 1;
  localparam int BIT_SRC    = 2;
  localparam int BIT_LVL_LO = 4;
  localparam int BIT_POST   = 8;
  localparam int BIT_PRE    = 9;
  localparam int BIT_TRG_LO = 12;
  localparam logic [31:0] FIXED_ONES = 32'h0000_0C08;

  // Level code to sample threshold; codes beyond 6 fold back to 32.
  function automatic logic [15:0] level_threshold(input logic [3:0] code);
    logic [15:0] t;
    if (code <= 4'd5)      t = 16'd32 << code;
    else if (code == 4'd6) t = 16'd1536;
    else                   t = 16'd32;
    return t;
  endfunction
endpackage

// File: rtl/acq_irq_sticky.sv
module acq_irq_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  a_r8_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o && !clr_i) |=> q_o);
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
endmodule

// File: rtl/acq_irq_edge_sync.sv
module acq_irq_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], async_i};
      prev  <= chain[STAGES-1];
    end
  end

  assign rise_o = chain[STAGES-1] & ~prev;

  a_r7_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/acq_irq_level_det.sv
module acq_irq_level_det #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] level_i,
  input  logic [3:0]       code_i,
  output logic             cross_o
);
  import acq_irq_pkg::*;
  logic [15:0] thr;
  logic        above, above_q;

  assign thr   = level_threshold(code_i);
  assign above = 32'(level_i) >= 32'(thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) above_q <= 1'b0;
    else        above_q <= above;
  end

  assign cross_o = above & ~above_q;

  a_r6_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    cross_o |=> !cross_o);
  a_r4_thr_range: assert property (@(posedge clk) disable iff (!rst_n)
    (thr >= 16'd32) && (thr <= 16'd1536));
endmodule

// File: rtl/acq_irq_ctrl.sv
module acq_irq_ctrl #(
  parameter int CNT_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [CNT_W-1:0] fifo_level,
  input  logic             dma_done,
  input  logic [1:0]       ext_trig,
  output logic             post_trig_en,
  output logic             pre_trig_en,
  output logic             irq
);
  import acq_irq_pkg::*;

  logic                ien, src_dma, post_q, pre_q;
  logic [3:0]          lvl_code;
  logic [NUM_TRIG-1:0] trig_en, trig_st, trig_rise;
  logic                fifo_cross, main_evt, main_st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien <= 1'b0; src_dma <= 1'b0; post_q <= 1'b0; pre_q <= 1'b0;
      lvl_code <= 4'd0; trig_en <= '0;
    end else if (reg_wr) begin
      ien      <= reg_wdata[BIT_IEN];
      src_dma  <= reg_wdata[BIT_SRC];
      lvl_code <= reg_wdata[BIT_LVL_LO +: 4];
      post_q   <= reg_wdata[BIT_POST];
      pre_q    <= reg_wdata[BIT_PRE];
      for (int k = 0; k < NUM_TRIG; k++)
        trig_en[k] <= reg_wdata[BIT_TRG_LO + 2*k];
    end
  end

  acq_irq_level_det #(.CNT_W(CNT_W)) u_level (
    .clk(clk), .rst_n(rst_n), .level_i(fifo_level),
    .code_i(lvl_code), .cross_o(fifo_cross)
  );

  assign main_evt = src_dma ? dma_done : fifo_cross;

  acq_irq_sticky u_main_st (
    .clk(clk), .rst_n(rst_n), .set_i(main_evt),
    .clr_i(reg_wr & reg_wdata[BIT_MST]), .q_o(main_st)
  );

  for (genvar g = 0; g < NUM_TRIG; g++) begin : g_trig
    acq_irq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_i(ext_trig[g]), .rise_o(trig_rise[g])
    );
    acq_irq_sticky u_st (
      .clk(clk), .rst_n(rst_n), .set_i(trig_rise[g]),
      .clr_i(reg_wr & reg_wdata[BIT_TRG_LO + 2*g + 1]), .q_o(trig_st[g])
    );
  end

  always_comb begin
    reg_rdata = FIXED_ONES;
    reg_rdata[BIT_IEN] = ien;
    reg_rdata[BIT_MST] = main_st;
    reg_rdata[BIT_SRC] = src_dma;
    reg_rdata[BIT_LVL_LO +: 4] = lvl_code;
    reg_rdata[BIT_POST] = post_q;
    reg_rdata[BIT_PRE]  = pre_q;
    for (int k = 0; k < NUM_TRIG; k++) begin
      reg_rdata[BIT_TRG_LO + 2*k]     = trig_en[k];
      reg_rdata[BIT_TRG_LO + 2*k + 1] = trig_st[k];
    end
  end

  assign irq          = (ien & main_st) | (|(trig_en & trig_st));
  assign post_trig_en = post_q;
  assign pre_trig_en  = pre_q;

  a_r9_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (main_st || (|trig_st)));
  a_r5_dma_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_dma && !fifo_cross && !main_st && !reg_wr) |=> !main_st);
  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[31:16] == 16'h0000);
endmodule

// File: tb/test_acq_irq_ctrl.sv
module test_acq_irq_ctrl;
  localparam int CNT_W = 11;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             reg_wr = 1'b0;
  logic [31:0]      reg_wdata = '0;
  logic [31:0]      reg_rdata;
  logic [CNT_W-1:0] fifo_level = '0;
  logic             dma_done = 1'b0;
  logic [1:0]       ext_trig = '0;
  logic             post_trig_en, pre_trig_en, irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  acq_irq_ctrl #(.CNT_W(CNT_W)) i_acq_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .fifo_level(fifo_level), .dma_done(dma_done),
    .ext_trig(ext_trig), .post_trig_en(post_trig_en),
    .pre_trig_en(pre_trig_en), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FIFO-less FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    reg_wr = 1'b1; reg_wdata = d;
    step();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  function automatic int exp_thr(input int code);
    int t;
    t = 32;
    if (code < 6) t = 32 * (2 ** code);
    if (code == 6) t = 1024 + 512;
    return t;
  endfunction

  initial begin
    int cyc;
    cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    step(2);
    // R1: reset state
    chk("R1 readback", reg_rdata, 32'h0000_0C08);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;
    step();
    chk("R1 after release", reg_rdata, 32'h0000_0C08);

    // R2/R3: field storage, fixed bits
    wr(32'hFFFF_5FF5);
    chk("R2 R3 fields", reg_rdata, 32'h0000_5FFD);
    chk("R2 post out", {31'b0, post_trig_en}, 32'h1);
    chk("R2 pre out", {31'b0, pre_trig_en}, 32'h1);
    wr(32'h0000_0100);
    chk("R2 R3 post only", reg_rdata, 32'h0000_0D08);
    chk("R2 pre cleared", {31'b0, pre_trig_en}, 32'h0);
    wr(32'h0000_0000);
    chk("R3 zero write", reg_rdata, 32'h0000_0C08);

    // R4/R6: threshold sweep over all codes
    for (int c = 0; c < 16; c++) begin
      int t;
      t = exp_thr(c);
      fifo_level = '0;
      wr(32'h0000_0003 | (32'(c) << 4));
      step();
      fifo_level = CNT_W'(t - 1);
      step();
      chk($sformatf("R4 code %0d below", c), {31'b0, reg_rdata[1]}, 32'h0);
      fifo_level = CNT_W'(t);
      step();
      chk($sformatf("R4 code %0d at", c), {31'b0, reg_rdata[1]}, 32'h1);
      chk($sformatf("R9 code %0d irq", c), {31'b0, irq}, 32'h1);
      wr(32'h0000_0003 | (32'(c) << 4));
      step(2);
      chk($sformatf("R6 code %0d held", c), {31'b0, reg_rdata[1]}, 32'h0);
    end

    // R5: source selection
    fifo_level = '0;
    wr(32'h0000_0002);
    step();
    dma_done = 1'b1; step(); dma_done = 1'b0;
    chk("R5 R10 dma ignored src0", {31'b0, reg_rdata[1]}, 32'h0);
    wr(32'h0000_0006);
    fifo_level = CNT_W'(40);
    step(2);
    chk("R5 fifo ignored src1", {31'b0, reg_rdata[1]}, 32'h0);
    dma_done = 1'b1; step(); dma_done = 1'b0;
    chk("R5 R10 dma sets", {31'b0, reg_rdata[1]}, 32'h1);
    chk("R10 irq gated", {31'b0, irq}, 32'h0);
    wr(32'h0000_0005);
    chk("R9 irq enabled", {31'b0, irq}, 32'h1);
    wr(32'h0000_0004);
    chk("R8 sticky on zero write", {31'b0, reg_rdata[1]}, 32'h1);
    // R8: simultaneous set and clear
    reg_wr = 1'b1; reg_wdata = 32'h0000_0006; dma_done = 1'b1;
    step();
    reg_wr = 1'b0; reg_wdata = '0; dma_done = 1'b0;
    chk("R8 set wins", {31'b0, reg_rdata[1]}, 32'h1);
    wr(32'h0000_0006);
    chk("R8 w1c", {31'b0, reg_rdata[1]}, 32'h0);
    fifo_level = '0;

    // R7/R10/R9: triggers
    for (int k = 0; k < 2; k++) begin
      int sb;
      sb = 13 + 2 * k;
      ext_trig[k] = 1'b1;
      step(2);
      chk($sformatf("R7 trig%0d edge2", k), {31'b0, reg_rdata[sb]}, 32'h0);
      step();
      chk($sformatf("R7 trig%0d edge3", k), {31'b0, reg_rdata[sb]}, 32'h1);
      chk($sformatf("R10 trig%0d irq off", k), {31'b0, irq}, 32'h0);
      wr(32'h1 << (sb - 1));
      chk($sformatf("R9 trig%0d irq on", k), {31'b0, irq}, 32'h1);
      wr(32'h1 << sb);
      step(4);
      chk($sformatf("R7 trig%0d held high", k), {31'b0, reg_rdata[sb]}, 32'h0);
      chk($sformatf("R9 trig%0d irq clear", k), {31'b0, irq}, 32'h0);
      ext_trig[k] = 1'b0;
      step(3);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule